// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block maps each 24-bit virtual address onto a 24-bit real address. The tables live in main memory and form a two-level tree. One origin register points at the segment table of the running address space. A segment entry gives the base of a page table, and the page entry gives the real frame. A context switch writes a new origin, and the table contents are never copied. Every access the processor makes passes through this block, whether it fetches an instruction or reads an operand.

A fully associative translation cache holds recent results and is refilled by the hardware. On a hit the answer comes back on the cycle after the request. On a miss a walker reads the segment entry, then reads the page entry through a simple read port, writes the result into the cache and answers. An invalid entry at either level ends the walk with a fault answer. Software can flush the whole cache with a single-cycle purge pulse. Loading a new origin flushes it as well. Only one translation is in progress at a time.

Top module: `xlat_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0. The cache is empty, so the first translation reads memory.
- R2: The virtual address splits into a segment index (bits 23:20), a page index (bits 19:12) and an offset (bits 11:0). On a miss the segment entry is read at origin + 4*segment. A segment entry is valid when bit 0 is 0, and its bits 23:6 give the page-table base (the low 6 bits of the base are zero). The page entry is then read in the low 16 bits of the word at base + 2*page. It is valid when bit 0 is 0, and its bits 15:4 give the frame. The answer is {frame, offset}.
- R3: A cache hit raises rsp_valid on the cycle after acceptance and makes no memory read.
- R4: A segment entry with bit 0 set gives rsp_fault=1 and rsp_raddr=0 after exactly one read. Nothing is cached, so a repeat of the request reads memory again.
- R5: A page entry with bit 0 set gives rsp_fault=1 and rsp_raddr=0 after two reads. Nothing is cached.
- R6: The cache holds 8 translations and replaces them in round-robin order. After 8 distinct fills, a ninth fill evicts the oldest entry and leaves the others resident.
- R7: A one-cycle purge pulse invalidates every cached translation.
- R8: A pulse on org_we loads org_addr as the new origin and invalidates every cached translation. Later walks start from the new origin.
- R9: req_ready stays 0 from the acceptance of a request until its response is taken. While rsp_ready is 0, rsp_valid, rsp_raddr and rsp_fault hold steady.
- R10: If a purge or an origin load arrives while a walk is in progress, the walk still answers correctly, but its result is not cached.
- R11: mem_req stays high with mem_addr unchanged until mem_ack is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 24 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_raddr | output | 24 | Real address (0 on a fault) |
| rsp_fault | output | 1 | Translation failed on an invalid entry |
| org_we | input | 1 | Load a new segment-table origin and flush the cache |
| org_addr | input | 24 | Real address of the new segment table |
| purge | input | 1 | Invalidate all cached translations |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 24 | Real address of the table entry |
| mem_ack | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench builds the block with its default parameters. These are a 4-bit segment index, an 8-bit page index, a 12-bit offset, a 12-bit frame and 8 cache entries. With only 8 entries, nine fills are enough to reach the round-robin wrap and the eviction of the oldest translation in a short run. The memory model in the bench answers after a latency that the bench sets per test. Long latencies leave room to inject a purge in the middle of a walk and to watch the held read request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_SEG  = 2'd1,
        W_PAGE = 2'd2,
        W_RESP = 2'd3
    } walk_st_e;

    // Entry field positions that the walker decodes
    localparam int XL_SEG_INV_BIT   = 0;
    localparam int XL_PT_ALIGN      = 6;
    localparam int XL_PG_INV_BIT    = 0;
    localparam int XL_PG_FRAME_LSB  = 4;
    localparam int XL_SEG_STRIDE_SH = 2;  // 4-byte segment entries
    localparam int XL_PG_STRIDE_SH  = 1;  // 2-byte page entries

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int VPN_W   = 12,
    parameter int FRAME_W = 12,
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               flush
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]              valid;
        logic [ENTRIES-1:0][VPN_W-1:0]   tag;
        logic [ENTRIES-1:0][FRAME_W-1:0] frame;
        logic [PTR_W-1:0]                ptr;
    } tlb_state_t;

    tlb_state_t s_q, s_d;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = s_q.valid[g] && (s_q.tag[g] == lk_vpn);
    end

    always_comb begin
        lk_frame = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_frame = lk_frame | s_q.frame[i];
        end
    end
    assign lk_hit = |match;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.valid = '0;
        end else if (fill_en) begin
            s_d.valid[s_q.ptr] = 1'b1;
            s_d.tag[s_q.ptr]   = fill_vpn;
            s_d.frame[s_q.ptr] = fill_frame;
            s_d.ptr            = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: a translation occupies at most one slot
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R7: nothing hits on the cycle after a flush
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    if (ENTRIES > 1) begin : g_rr_chk
        // R6: each fill moves the replacement pointer on
        a_r6_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en && !flush) |=> (s_q.ptr != $past(s_q.ptr)));
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 12,
    parameter int MEM_DW  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [FRAME_W+OFF_W-1:0] rsp_raddr,
    output logic                   rsp_fault,
    input  logic [FRAME_W+OFF_W-1:0] origin,
    input  logic                   kill,
    input  logic                   lk_hit,
    input  logic [FRAME_W-1:0]     lk_frame,
    output logic                   fill_en,
    output logic [SEG_W+PAGE_W-1:0] fill_vpn,
    output logic [FRAME_W-1:0]     fill_frame,
    output logic                   mem_req,
    output logic [FRAME_W+OFF_W-1:0] mem_addr,
    input  logic                   mem_ack,
    input  logic [MEM_DW-1:0]      mem_rdata
);
    localparam int VA_W = SEG_W + PAGE_W + OFF_W;
    localparam int RA_W = FRAME_W + OFF_W;
    localparam int SEG_PAD = RA_W - SEG_W - XL_SEG_STRIDE_SH;
    localparam int PG_PAD  = RA_W - PAGE_W - XL_PG_STRIDE_SH;

    typedef struct packed {
        walk_st_e          st;
        logic [VA_W-1:0]   vaddr;
        logic [RA_W-1:0]   maddr;
        logic [RA_W-1:0]   raddr;
        logic              fault;
        logic              nofill;
    } walk_state_t;

    walk_state_t w_q, w_d;

    logic [SEG_W-1:0]   req_seg;
    logic [PAGE_W-1:0]  cur_page;
    logic [OFF_W-1:0]   req_off;
    logic [OFF_W-1:0]   cur_off;
    logic [RA_W-1:0]    pt_base;
    logic [FRAME_W-1:0] pg_frame;
    logic               unused_rdata;

    assign req_seg  = req_vaddr[VA_W-1 -: SEG_W];
    assign req_off  = req_vaddr[OFF_W-1:0];
    assign cur_page = w_q.vaddr[OFF_W +: PAGE_W];
    assign cur_off  = w_q.vaddr[OFF_W-1:0];
    assign pt_base  = {mem_rdata[RA_W-1:XL_PT_ALIGN], {XL_PT_ALIGN{1'b0}}};
    assign pg_frame = mem_rdata[XL_PG_FRAME_LSB +: FRAME_W];
    assign unused_rdata = ^{mem_rdata[MEM_DW-1:RA_W], mem_rdata[XL_PG_FRAME_LSB-1:1]};

    always_comb begin
        w_d       = w_q;
        req_ready = 1'b0;
        mem_req   = 1'b0;
        fill_en   = 1'b0;
        unique case (w_q.st)
            W_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    w_d.vaddr  = req_vaddr;
                    w_d.nofill = kill;
                    if (lk_hit) begin
                        w_d.raddr = {lk_frame, req_off};
                        w_d.fault = 1'b0;
                        w_d.st    = W_RESP;
                    end else begin
                        w_d.maddr = origin +
                            {{SEG_PAD{1'b0}}, req_seg, {XL_SEG_STRIDE_SH{1'b0}}};
                        w_d.st    = W_SEG;
                    end
                end
            end
            W_SEG: begin
                mem_req    = 1'b1;
                w_d.nofill = w_q.nofill | kill;
                if (mem_ack) begin
                    if (mem_rdata[XL_SEG_INV_BIT]) begin
                        w_d.fault = 1'b1;
                        w_d.raddr = '0;
                        w_d.st    = W_RESP;
                    end else begin
                        w_d.maddr = pt_base +
                            {{PG_PAD{1'b0}}, cur_page, {XL_PG_STRIDE_SH{1'b0}}};
                        w_d.st    = W_PAGE;
                    end
                end
            end
            W_PAGE: begin
                mem_req    = 1'b1;
                w_d.nofill = w_q.nofill | kill;
                if (mem_ack) begin
                    w_d.st = W_RESP;
                    if (mem_rdata[XL_PG_INV_BIT]) begin
                        w_d.fault = 1'b1;
                        w_d.raddr = '0;
                    end else begin
                        w_d.fault = 1'b0;
                        w_d.raddr = {pg_frame, cur_off};
                        fill_en   = !(w_q.nofill || kill);
                    end
                end
            end
            W_RESP: begin
                if (rsp_ready) w_d.st = W_IDLE;
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= W_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign rsp_valid  = (w_q.st == W_RESP);
    assign rsp_raddr  = w_q.raddr;
    assign rsp_fault  = w_q.fault;
    assign mem_addr   = w_q.maddr;
    assign fill_vpn   = w_q.vaddr[VA_W-1:OFF_W];
    assign fill_frame = pg_frame;

    // R11: a pending read keeps its request and address
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9: a stalled response does not change
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_raddr) && $stable(rsp_fault)));

    // R9: no new request while a response is pending
    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R3: a hit answers next cycle without reading memory
    a_r3_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (rsp_valid && !mem_req));

    // R4 / R5: a fault answer never follows a fill
    a_r4_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_fault) |-> !$past(fill_en));

endmodule

// File: rtl/xlat_top.sv
module xlat_top #(
    parameter int SEG_W   = 4,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 12,
    parameter int ENTRIES = 8,
    parameter int MEM_DW  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
    output logic                         rsp_valid,
    input  logic                         rsp_ready,
    output logic [FRAME_W+OFF_W-1:0]     rsp_raddr,
    output logic                         rsp_fault,
    input  logic                         org_we,
    input  logic [FRAME_W+OFF_W-1:0]     org_addr,
    input  logic                         purge,
    output logic                         mem_req,
    output logic [FRAME_W+OFF_W-1:0]     mem_addr,
    input  logic                         mem_ack,
    input  logic [MEM_DW-1:0]            mem_rdata
);
    localparam int VA_W  = SEG_W + PAGE_W + OFF_W;
    localparam int RA_W  = FRAME_W + OFF_W;
    localparam int VPN_W = SEG_W + PAGE_W;

    typedef struct packed {
        logic [RA_W-1:0] origin;
    } top_state_t;

    top_state_t t_q, t_d;

    logic               kill;
    logic               lk_hit;
    logic [FRAME_W-1:0] lk_frame;
    logic               fill_en;
    logic [VPN_W-1:0]   fill_vpn;
    logic [FRAME_W-1:0] fill_frame;

    assign kill = purge | org_we;

    always_comb begin
        t_d = t_q;
        if (org_we) t_d.origin = org_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    xlat_tlb #(
        .VPN_W   (VPN_W),
        .FRAME_W (FRAME_W),
        .ENTRIES (ENTRIES)
    ) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (req_vaddr[VA_W-1:OFF_W]),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_frame (fill_frame),
        .flush      (kill)
    );

    xlat_walker #(
        .SEG_W   (SEG_W),
        .PAGE_W  (PAGE_W),
        .OFF_W   (OFF_W),
        .FRAME_W (FRAME_W),
        .MEM_DW  (MEM_DW)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_raddr  (rsp_raddr),
        .rsp_fault  (rsp_fault),
        .origin     (t_q.origin),
        .kill       (kill),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_frame (fill_frame),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    // R8: an origin load takes the presented address
    a_r8_origin_load: assert property (@(posedge clk) disable iff (!rst_n)
        org_we |=> (t_q.origin == $past(org_addr)));

    // R10: no fill in the cycle of a purge or origin load
    a_r10_kill_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> !fill_en);

endmodule

// File: tb/sim_xlat_top.sv
module sim_xlat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [23:0] rsp_raddr;
    logic        rsp_fault;
    logic        org_we = 1'b0;
    logic [23:0] org_addr = '0;
    logic        purge = 1'b0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    xlat_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_raddr(rsp_raddr),
        .rsp_fault(rsp_fault), .org_we(org_we), .org_addr(org_addr),
        .purge(purge), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int mem_lat = 2;
    int rd_cnt = 0;
    int hold_err = 0;
    logic [23:0] rd_log [$];
    logic [31:0] mem [logic [23:0]];

    localparam logic [23:0] ORG_A = 24'h010000;
    localparam logic [23:0] ORG_B = 24'h030000;
    localparam logic [23:0] PT_A  = 24'h020000;
    localparam logic [23:0] PT_B  = 24'h040000;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: answers after mem_lat cycles, one-cycle ack
    initial begin : mem_model
        int cnt = 0;
        logic [23:0] held = '0;
        forever begin
            @(negedge clk);
            #1;
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt > 0 && mem_addr != held) hold_err++;
                held = mem_addr;
                cnt++;
                if (cnt >= mem_lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h1;
                    rd_log.push_back(mem_addr);
                    rd_cnt++;
                end
            end
        end
    end

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic map_page(input logic [23:0] org, input logic [3:0] seg,
                            input logic [23:0] pt, input logic [7:0] pg, input logic [11:0] frame);
        mem[org + {18'd0, seg, 2'b00}] = {8'd0, pt};
        mem[pt + {15'd0, pg, 1'b0}] = {16'd0, frame, 4'h0};
    endtask

    task automatic load_origin(input logic [23:0] a);
        @(negedge clk);
        org_we = 1'b1;
        org_addr = a;
        @(negedge clk);
        org_we = 1'b0;
    endtask

    task automatic do_purge();
        @(negedge clk);
        purge = 1'b1;
        @(negedge clk);
        purge = 1'b0;
    endtask

    task automatic xlate(input logic [23:0] va, input int hold, input bit mid_purge,
                         output logic [23:0] ra, output bit flt, output int nrd, output int lat);
        int rd0;
        int guard;
        @(negedge clk);
        rd0 = rd_cnt;
        req_valid = 1'b1;
        req_vaddr = va;
        rsp_ready = (hold == 0);
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_purge) purge = 1'b1;
        lat = 1;
        guard = 0;
        while (!rsp_valid && guard < 200) begin
            chk(req_ready == 1'b0, "R9 ready low during walk", {31'd0, req_ready}, 0);
            @(negedge clk);
            purge = 1'b0;
            lat++;
            guard++;
        end
        purge = 1'b0;
        ra = rsp_raddr;
        flt = rsp_fault;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_raddr == ra && rsp_fault == flt && !req_ready,
                "R9 response held", {7'd0, rsp_valid, rsp_raddr}, {8'd1, ra});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        nrd = rd_cnt - rd0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", {31'd0, mem_req}, 0);
    endtask

    task automatic t_miss_then_hit();
        logic [23:0] ra; bit f; int n, l;
        load_origin(ORG_A);
        map_page(ORG_A, 4'h1, PT_A, 8'h05, 12'h3C7);
        rd_log.delete();
        xlate(24'h105ABC, 0, 1'b0, ra, f, n, l);
        chk(n == 2, "R1 first access reads memory", n, 2);
        chk(ra == 24'h3C7ABC && !f, "R2 walked address", {7'd0, f, ra}, 32'h3C7ABC);
        chk(rd_log.size() == 2 && rd_log[0] == ORG_A + 24'h4, "R2 segment entry address",
            rd_log.size() > 0 ? {8'd0, rd_log[0]} : 0, {8'd0, ORG_A + 24'h4});
        chk(rd_log.size() == 2 && rd_log[1] == PT_A + 24'hA, "R2 page entry address",
            rd_log.size() > 1 ? {8'd0, rd_log[1]} : 0, {8'd0, PT_A + 24'hA});
        xlate(24'h105123, 0, 1'b0, ra, f, n, l);
        chk(n == 0 && l == 1, "R3 hit latency and no read", l * 16 + n, 16);
        chk(ra == 24'h3C7123 && !f, "R3 hit address", {7'd0, f, ra}, 32'h3C7123);
    endtask

    task automatic t_seg_fault();
        logic [23:0] ra; bit f; int n, l;
        mem[ORG_A + 24'h8] = 32'h1;
        for (int k = 0; k < 2; k++) begin
            xlate(24'h200040, 0, 1'b0, ra, f, n, l);
            chk(f && ra == 24'h0, "R4 segment fault response", {7'd0, f, ra}, 32'h1000000);
            chk(n == 1, "R4 one read, no fill", n, 1);
        end
    endtask

    task automatic t_page_fault();
        logic [23:0] ra; bit f; int n, l;
        mem[PT_A + 24'hC] = 32'h0001;
        for (int k = 0; k < 2; k++) begin
            xlate(24'h106010, 0, 1'b0, ra, f, n, l);
            chk(f && ra == 24'h0, "R5 page fault response", {7'd0, f, ra}, 32'h1000000);
            chk(n == 2, "R5 two reads, no fill", n, 2);
        end
    endtask

    task automatic t_round_robin();
        logic [23:0] ra; bit f; int n, l;
        do_purge();
        for (int p = 0; p < 9; p++) map_page(ORG_A, 4'h1, PT_A, 8'h10 + p[7:0], 12'h500 + p[11:0]);
        for (int p = 0; p < 9; p++) begin
            xlate({4'h1, 8'h10 + p[7:0], 12'h000}, 0, 1'b0, ra, f, n, l);
            chk(n == 2 && ra == {12'h500 + p[11:0], 12'h000}, "R6 fill walk",
                {8'd0, ra}, {8'd0, 12'h500 + p[11:0], 12'h000});
        end
        xlate(24'h111777, 0, 1'b0, ra, f, n, l);
        chk(n == 0 && ra == 24'h501777, "R6 second entry still resident", n, 0);
        xlate(24'h110777, 0, 1'b0, ra, f, n, l);
        chk(n == 2 && ra == 24'h500777, "R6 oldest entry evicted", n, 2);
    endtask

    task automatic t_purge();
        logic [23:0] ra; bit f; int n, l;
        xlate(24'h112000, 0, 1'b0, ra, f, n, l);
        chk(n == 0, "R7 resident before purge", n, 0);
        do_purge();
        xlate(24'h112000, 0, 1'b0, ra, f, n, l);
        chk(n == 2 && ra == 24'h502000, "R7 miss after purge", n, 2);
    endtask

    task automatic t_origin();
        logic [23:0] ra; bit f; int n, l;
        map_page(ORG_B, 4'h1, PT_B, 8'h05, 12'h155);
        load_origin(ORG_B);
        rd_log.delete();
        xlate(24'h105ABC, 0, 1'b0, ra, f, n, l);
        chk(ra == 24'h155ABC && n == 2, "R8 new table tree used", {8'd0, ra}, 32'h155ABC);
        chk(rd_log.size() > 0 && rd_log[0] == ORG_B + 24'h4, "R8 walk starts at new origin",
            rd_log.size() > 0 ? {8'd0, rd_log[0]} : 0, {8'd0, ORG_B + 24'h4});
        load_origin(ORG_A);
        xlate(24'h105ABC, 0, 1'b0, ra, f, n, l);
        chk(ra == 24'h3C7ABC && n == 2, "R8 origin reload flushes cache", {8'd0, ra}, 32'h3C7ABC);
    endtask

    task automatic t_hold();
        logic [23:0] ra; bit f; int n, l;
        xlate(24'h105001, 3, 1'b0, ra, f, n, l);
        chk(ra == 24'h3C7001, "R9 held hit result", {8'd0, ra}, 32'h3C7001);
        xlate(24'h120000, 2, 1'b0, ra, f, n, l);
        chk(f == 1'b1, "R9 held fault result", {31'd0, f}, 1);
    endtask

    task automatic t_mid_purge();
        logic [23:0] ra; bit f; int n, l;
        mem_lat = 4;
        map_page(ORG_A, 4'h1, PT_A, 8'h30, 12'h777);
        xlate(24'h130444, 0, 1'b1, ra, f, n, l);
        chk(ra == 24'h777444 && !f && n == 2, "R10 walk answers despite purge", {8'd0, ra}, 32'h777444);
        xlate(24'h130444, 0, 1'b0, ra, f, n, l);
        chk(n == 2, "R10 result not cached", n, 2);
        xlate(24'h130444, 0, 1'b0, ra, f, n, l);
        chk(n == 0, "R10 normal fill afterwards", n, 0);
        chk(hold_err == 0, "R11 address held until ack", hold_err, 0);
        mem_lat = 2;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_then_hit();
        t_seg_fault();
        t_page_fault();
        t_round_robin();
        t_purge();
        t_origin();
        t_hold();
        t_mid_purge();
        chk(hold_err == 0, "R11 no request dropped or moved", hold_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule